// File: doc/BRIEF.md
# Multi-Format Serial Transmitter

This block is the sending half of a serial port. A host writes one character at a time into a holding register. The block moves the character into a shift register and drives it onto a single serial data line. Two transfer modes are available.

In start-stop (asynchronous) mode, each character is wrapped in a frame:
- a low start bit,
- 7 or 8 data bits, least significant first,
- an optional extra bit, which is either a parity bit (even or odd) or a multiprocessor address/data flag,
- one or two high stop bits.

In clocked synchronous mode, exactly 8 data bits are shifted out with no framing bits. The timing is set by a serial clock.

The bit timing comes from one of two sources:
- a one-cycle enable pulse from an external rate divider, or
- falling edges seen on an external clock input.

When the internal source is used in synchronous mode, the block drives the serial clock pin itself. Because of the holding register, the host can supply the next character while the current one is still being sent. Frames then follow one another without any idle time. A holding-empty flag tells the host when it may write. A transmit-end flag tells it when the line has gone quiet.

Top module: `sertx_top`

## Requirements
- R1: `mode_sync`=0 selects start-stop framing. `mode_sync`=1 selects clocked synchronous transfer, whose first bit on `txd` is data bit 0 (there is no start bit).
- R2: The line idles high (`txd`=1). A start-stop frame begins with a start bit of 0, followed by the data bits least significant first. `txd` changes only on a bit advance.
- R3: `len_short`=1 sends 7 data bits (`wr_data[6:0]`; bit 7 is not sent). `len_short`=0 sends 8 data bits.
- R4: `stop_two`=0 ends the frame with one stop bit of 1. `stop_two`=1 ends it with two.
- R5: With `par_en`=1 and `mp_en`=0, a parity bit follows the data bits:
  - `par_odd`=0 makes the count of ones over the data bits and the parity bit even;
  - `par_odd`=1 makes that count odd;
  - `par_en`=0 sends no parity bit.
- R6: With `mp_en`=1, the bit that follows the data bits is the `wr_mp` value captured at the write, and `par_en`/`par_odd` are ignored. This gives 12 start-stop formats in total.
- R7: A write is accepted only when `hold_empty`=1, and `hold_empty` then goes to 0.
  - A write while `hold_empty`=0 is ignored.
  - `hold_empty` returns to 1 when the shift register takes the character.
  - A character held when the previous frame's last bit ends starts on the very next bit advance, with no idle bit.
- R8: In synchronous mode with the internal source, each rate pulse alternates between two actions:
  - one pulse drives `sclk_out` low and puts the next bit on `txd`;
  - the next pulse drives `sclk_out` high, with `txd` unchanged.

  `sclk_out` stays high while nothing is being sent.
- R9: `ext_clk_sel`=0 takes bit advances from `rate_tick`. `ext_clk_sel`=1 takes them from falling edges of `sclk_in`, which arrive after a two-stage synchroniser. `sclk_oe`=1 only when `mode_sync`=1 and `ext_clk_sel`=0; otherwise `sclk_out` stays 1.
- R10: `tx_done` goes to 1 on the bit advance that ends the last bit of a frame when no character is held. It goes to 0 when a write is accepted.
- R11: After reset: `txd`=1, `sclk_out`=1, `hold_empty`=1, `tx_done`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Character to send |
| wr_mp | input | 1 | Multiprocessor flag value for this character |
| hold_empty | output | 1 | Holding register can accept a write |
| tx_done | output | 1 | Line idle and nothing held |
| mode_sync | input | 1 | 0 start-stop, 1 clocked synchronous |
| ext_clk_sel | input | 1 | 0 rate pulse source, 1 external clock pin |
| len_short | input | 1 | 7-bit character in start-stop mode |
| par_en | input | 1 | Append parity bit |
| par_odd | input | 1 | Odd parity when set |
| mp_en | input | 1 | Append multiprocessor flag instead of parity |
| stop_two | input | 1 | Two stop bits |
| rate_tick | input | 1 | One-cycle bit-rate enable from the divider |
| sclk_in | input | 1 | External serial clock |
| txd | output | 1 | Serial data line |
| sclk_out | output | 1 | Driven serial clock |
| sclk_oe | output | 1 | Serial clock output enable |

## Verification
The bench builds the block with its default parameters:
- `DATA_W`=8, so the frame is 12 bits wide and can reach every length from 9 to 12 bits;
- `SYNC_STAGES`=2, which fixes the latency from an `sclk_in` edge to a bit change at three cycles, well inside the six-cycle wait the bench uses.

With these values, a single table of twelve rows covers every start-stop format:
- both character lengths;
- both stop lengths;
- parity none, even and odd;
- the multiprocessor flag at both values, including a row where parity is requested and must be ignored.

Directed tests then cover back-to-back frames, the synchronous clock phases and the external-clock path.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef struct packed {
    logic sync;
    logic len_short;
    logic par_en;
    logic par_odd;
    logic mp_en;
    logic stop2;
  } fmt_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mp,
  input  logic              take,
  output logic              full,
  output logic              wr_accept,
  output logic [DATA_W-1:0] data_q,
  output logic              mp_q
);

  assign wr_accept = wr_en && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full   <= 1'b0;
      data_q <= '0;
      mp_q   <= 1'b0;
    end else if (wr_accept) begin
      full   <= 1'b1;
      data_q <= wr_data;
      mp_q   <= wr_mp;
    end else if (take) begin
      full   <= 1'b0;
    end
  end

  // R7: the shifter only takes a character that is actually held
  p_take_when_full_r7: assert property (@(posedge clk) disable iff (rst)
    take |-> full);

  // R7: an accepted write leaves the register full
  p_write_fills_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !full) |=> full);

endmodule

// File: rtl/sertx_clkgen.sv
module sertx_clkgen #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_sync,
  input  logic ext_sel,
  input  logic rate_tick,
  input  logic sclk_in,
  input  logic work,
  input  logic cont,
  output logic adv,
  output logic sclk_out,
  output logic sclk_oe
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sq;
  logic                   prev_q;
  logic                   phase_q;
  logic                   fall_ext;
  logic                   int_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq     <= '1;
      prev_q <= 1'b1;
    end else begin
      sq     <= {sq[SYNC_STAGES-2:0], sclk_in};
      prev_q <= sq[LAST];
    end
  end

  assign fall_ext = prev_q && !sq[LAST];
  assign int_sync = mode_sync && !ext_sel;
  assign sclk_oe  = int_sync;

  always_comb begin
    if (ext_sel)        adv = fall_ext;
    else if (!mode_sync) adv = rate_tick;
    else                 adv = rate_tick && !phase_q && work;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 1'b0;
      sclk_out <= 1'b1;
    end else if (int_sync && rate_tick) begin
      if (phase_q) begin
        sclk_out <= 1'b1;
        phase_q  <= 1'b0;
      end else if (cont) begin
        sclk_out <= 1'b0;
        phase_q  <= 1'b1;
      end
    end
  end

  // R9: the clock pin is only pulled low when the block owns it
  p_sclk_low_owned_r9: assert property (@(posedge clk) disable iff (rst)
    !sclk_out |-> sclk_oe);

  // R8: a low clock phase always returns high on the next rate pulse
  p_sclk_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (!sclk_out && rate_tick && int_sync) |=> sclk_out);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  fmt_t              fmt,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_mp,
  input  logic              wr_accept,
  output logic              take,
  output logic              busy,
  output logic              cont,
  output logic              txd,
  output logic              tx_done
);

  localparam int unsigned FRAME_W = DATA_W + 4;
  localparam int unsigned CW      = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_new;
  logic [CW-1:0]      cnt_q;
  logic [CW-1:0]      n_new;
  logic               last_bit;
  logic               par_bit;
  logic               extra_bit;
  logic               has_extra;
  logic [DATA_W-1:0]  data_mask;
  int unsigned        dbits;

  assign last_bit = busy && (cnt_q == CW'(1));
  assign cont     = (busy && !last_bit) || hold_full;
  assign take     = adv && (!busy || last_bit) && hold_full;

  always_comb begin
    dbits     = fmt.len_short ? DATA_W - 1 : DATA_W;
    data_mask = fmt.len_short ? {1'b0, {(DATA_W-1){1'b1}}} : '1;
    par_bit   = (^(hold_data & data_mask)) ^ fmt.par_odd;
    has_extra = fmt.mp_en || fmt.par_en;
    extra_bit = fmt.mp_en ? hold_mp : par_bit;
    frame_new = '1;
    if (fmt.sync) begin
      frame_new[DATA_W-1:0] = hold_data;
      n_new = CW'(DATA_W);
    end else begin
      frame_new[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (i < dbits) frame_new[1+i] = hold_data[i];
      end
      if (has_extra) frame_new[1+dbits] = extra_bit;
      n_new = CW'(2 + dbits + (has_extra ? 1 : 0) + (fmt.stop2 ? 1 : 0));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      frame_q <= '1;
      cnt_q   <= '0;
      txd     <= 1'b1;
      tx_done <= 1'b1;
    end else begin
      if (adv) begin
        if (!busy || last_bit) begin
          if (hold_full) begin
            txd     <= frame_new[0];
            frame_q <= {1'b1, frame_new[FRAME_W-1:1]};
            cnt_q   <= n_new;
            busy    <= 1'b1;
          end else begin
            busy <= 1'b0;
            txd  <= 1'b1;
            if (busy) tx_done <= 1'b1;
          end
        end else begin
          txd     <= frame_q[0];
          frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
          cnt_q   <= cnt_q - CW'(1);
        end
      end
      if (wr_accept) tx_done <= 1'b0;
    end
  end

  // R2: the line is high whenever no frame is in flight
  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  // R2: the data line moves only on a bit advance
  p_txd_steady_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(adv) |-> $stable(txd));

  // R10: end-of-transmission never coexists with a held character
  p_done_empty_r10: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> !hold_full);

  // R10: end flag only while the shifter is idle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> !busy);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mp,
  output logic              hold_empty,
  output logic              tx_done,
  input  logic              mode_sync,
  input  logic              ext_clk_sel,
  input  logic              len_short,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              mp_en,
  input  logic              stop_two,
  input  logic              rate_tick,
  input  logic              sclk_in,
  output logic              txd,
  output logic              sclk_out,
  output logic              sclk_oe
);

  fmt_t              fmt;
  logic              hold_full;
  logic              wr_accept;
  logic [DATA_W-1:0] hold_data;
  logic              hold_mp;
  logic              take;
  logic              busy;
  logic              cont;
  logic              adv;

  assign fmt = '{sync: mode_sync, len_short: len_short, par_en: par_en,
                 par_odd: par_odd, mp_en: mp_en, stop2: stop_two};
  assign hold_empty = !hold_full;

  sertx_hold #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_mp(wr_mp),
    .take(take), .full(hold_full), .wr_accept(wr_accept),
    .data_q(hold_data), .mp_q(hold_mp)
  );

  sertx_clkgen #(.SYNC_STAGES(SYNC_STAGES)) clkgen_i (
    .clk(clk), .rst(rst), .mode_sync(mode_sync), .ext_sel(ext_clk_sel),
    .rate_tick(rate_tick), .sclk_in(sclk_in), .work(busy || hold_full),
    .cont(cont), .adv(adv), .sclk_out(sclk_out), .sclk_oe(sclk_oe)
  );

  sertx_shift #(.DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst(rst), .adv(adv), .fmt(fmt), .hold_full(hold_full),
    .hold_data(hold_data), .hold_mp(hold_mp), .wr_accept(wr_accept),
    .take(take), .busy(busy), .cont(cont), .txd(txd), .tx_done(tx_done)
  );

  // R7: a write to a full holding register leaves it full
  p_full_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hold_empty && !take) |=> !hold_empty);

endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_mp = 1'b0;
  logic       hold_empty, tx_done, txd, sclk_out, sclk_oe;
  logic       mode_sync = 1'b0, ext_clk_sel = 1'b0, len_short = 1'b0;
  logic       par_en = 1'b0, par_odd = 1'b0, mp_en = 1'b0, stop_two = 1'b0;
  logic       rate_tick = 1'b0, sclk_in = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sertx_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_mp(wr_mp),
    .hold_empty(hold_empty), .tx_done(tx_done), .mode_sync(mode_sync),
    .ext_clk_sel(ext_clk_sel), .len_short(len_short), .par_en(par_en),
    .par_odd(par_odd), .mp_en(mp_en), .stop_two(stop_two),
    .rate_tick(rate_tick), .sclk_in(sclk_in), .txd(txd),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe)
  );

  // {data[7:0], len_short, par_en, par_odd, mp_en, mp_bit, stop_two, nbits[3:0]}
  localparam logic [17:0] VEC [0:11] = '{
    {8'hA5, 6'b000000, 4'd10},
    {8'hA5, 6'b000001, 4'd11},
    {8'h3C, 6'b010000, 4'd11},
    {8'h3C, 6'b011001, 4'd12},
    {8'hD3, 6'b100000, 4'd9},
    {8'hD3, 6'b100001, 4'd10},
    {8'h51, 6'b110000, 4'd10},
    {8'h51, 6'b111001, 4'd11},
    {8'h96, 6'b000110, 4'd11},
    {8'h96, 6'b010101, 4'd12},
    {8'h6E, 6'b100110, 4'd10},
    {8'h6E, 6'b100101, 4'd11}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) rate_tick = 1'b1;
    @(negedge clk) rate_tick = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] d, input logic m);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; wr_mp = m; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  function automatic logic [11:0] model_frame(input logic [7:0] d, input logic l7,
      input logic pe, input logic po, input logic mp, input logic mpb);
    logic [11:0] f;
    int db;
    int ones;
    f = '1;
    f[0] = 1'b0;
    db = l7 ? 7 : 8;
    ones = 0;
    for (int i = 0; i < db; i++) begin
      f[1+i] = d[i];
      if (d[i]) ones++;
    end
    if (mp) f[1+db] = mpb;
    else if (pe) f[1+db] = po ? ((ones % 2) == 0) : ((ones % 2) == 1);
    return f;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] exp_f, got_f, mask;
    int nb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(txd == 1'b1, "R11 txd", txd, 1);
    check(sclk_out == 1'b1, "R11 sclk_out", sclk_out, 1);
    check(hold_empty == 1'b1, "R11 hold_empty", hold_empty, 1);
    check(tx_done == 1'b1, "R11 tx_done", tx_done, 1);

    // table of start-stop formats: R2 R3 R4 R5 R6 R10
    for (int v = 0; v < 12; v++) begin
      len_short = VEC[v][9]; par_en = VEC[v][8]; par_odd = VEC[v][7];
      mp_en = VEC[v][6]; stop_two = VEC[v][4];
      nb = int'(VEC[v][3:0]);
      exp_f = model_frame(VEC[v][17:10], VEC[v][9], VEC[v][8], VEC[v][7],
                          VEC[v][6], VEC[v][5]);
      host_write(VEC[v][17:10], VEC[v][5]);
      check(tx_done == 1'b0, "R10 done cleared by write", tx_done, 0);
      got_f = '1;
      mask = '0;
      for (int k = 0; k < nb; k++) begin
        tick();
        got_f[k] = txd;
        mask[k] = 1'b1;
      end
      check((got_f & mask) == (exp_f & mask), "R2/R3/R4/R5/R6 frame", got_f & mask, exp_f & mask);
      check(tx_done == 1'b0, "R10 not done during last bit", tx_done, 0);
      tick();
      check(txd == 1'b1 && tx_done == 1'b1, "R10 done after last stop", {txd, tx_done}, 3);
    end

    // R7 back to back, write while full ignored
    len_short = 0; par_en = 0; par_odd = 0; mp_en = 0; stop_two = 0;
    host_write(8'h55, 1'b0);
    tick();
    got_f = '1;
    got_f[0] = txd;
    check(hold_empty == 1'b1, "R7 hold empties on load", hold_empty, 1);
    host_write(8'hF0, 1'b0);
    check(hold_empty == 1'b0, "R7 hold full after write", hold_empty, 0);
    host_write(8'h11, 1'b0);
    for (int k = 1; k < 10; k++) begin
      tick();
      got_f[k] = txd;
    end
    exp_f = model_frame(8'h55, 0, 0, 0, 0, 0);
    check(got_f[9:0] == exp_f[9:0], "R7 first frame", got_f[9:0], exp_f[9:0]);
    got_f = '1;
    for (int k = 0; k < 10; k++) begin
      tick();
      got_f[k] = txd;
    end
    exp_f = model_frame(8'hF0, 0, 0, 0, 0, 0);
    check(got_f[9:0] == exp_f[9:0], "R7 second frame with no gap", got_f[9:0], exp_f[9:0]);
    tick();
    check(txd == 1'b1 && tx_done == 1'b1, "R7 ignored write not sent", {txd, tx_done}, 3);
    tick();
    check(txd == 1'b1, "R7 line stays idle", txd, 1);

    // R1 R8 synchronous internal clock
    mode_sync = 1'b1; ext_clk_sel = 1'b0;
    @(negedge clk);
    check(sclk_oe == 1'b1 && sclk_out == 1'b1, "R9 sclk driven high idle", {sclk_oe, sclk_out}, 3);
    host_write(8'hC9, 1'b0);
    for (int k = 0; k < 8; k++) begin
      tick();
      check(sclk_out == 1'b0 && txd == wr_data[k], "R1/R8 falling phase bit",
            {sclk_out, txd}, {1'b0, wr_data[k]});
      tick();
      check(sclk_out == 1'b1 && txd == wr_data[k], "R8 rising phase hold",
            {sclk_out, txd}, {1'b1, wr_data[k]});
    end
    tick();
    check(sclk_out == 1'b1 && tx_done == 1'b1 && txd == 1'b1, "R8/R10 sync end",
          {sclk_out, tx_done, txd}, 7);

    // R9 synchronous external clock
    ext_clk_sel = 1'b1;
    @(negedge clk);
    check(sclk_oe == 1'b0, "R9 sclk not driven", sclk_oe, 0);
    host_write(8'h3A, 1'b0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk) sclk_in = 1'b0;
      repeat (6) @(negedge clk);
      check(txd == wr_data[k] && sclk_out == 1'b1, "R9 external clock bit",
            {sclk_out, txd}, {1'b1, wr_data[k]});
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    sclk_in = 1'b0;
    repeat (6) @(negedge clk);
    check(txd == 1'b1 && tx_done == 1'b1, "R9/R10 external end", {txd, tx_done}, 3);
    sclk_in = 1'b1;
    repeat (6) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule